// File: doc/BRIEF.md
# On-chip RAM address remapper

This block decodes 32-bit bus addresses for a 256 KiB on-chip RAM that shares the address space with a boot ROM which must stay invisible to users. It has two mappings. After reset the RAM is split: a 192 KiB window starting at address zero and a 64 KiB window ending at the top of the address space. When the remap control input is raised, the whole RAM appears as one 256 KiB window ending at the top of the address space. Addresses outside the active windows miss. No address in either mapping ever selects the boot ROM.

Each valid request is decoded in one registered stage. The result is a hit flag, a RAM word address (byte offset shifted right by two), the 64 KiB bank number of that word, and a one-cycle error flag for a request that missed. The remap input is sampled on the clock, so a request presented on the same edge as a change of that input is still decoded with the previous mapping.

Top module: `ocm_addr_remap`

## Requirements
- R1: While reset is high and on the first cycle after it, hit, err, word_addr and bank_sel are all 0, and the mapping is the split mapping.
- R2: In the split mapping a valid request to 0x0000_0000..0x0002_FFFF gives hit=1, err=0 and word_addr = address[17:2] on the next cycle.
- R3: In the split mapping a valid request to 0xFFFF_0000..0xFFFF_FFFF gives hit=1, err=0 and word_addr = 0xC000 + address[15:2] on the next cycle.
- R4: In the split mapping a valid request to 0x0003_0000..0xFFFE_FFFF gives hit=0, err=1, word_addr=0 and bank_sel=0 on the next cycle; hit and err are never both 1.
- R5: In the flat mapping a valid request to 0xFFFC_0000..0xFFFF_FFFF gives hit=1, err=0 and word_addr = address[17:2] on the next cycle.
- R6: In the flat mapping every valid request below 0xFFFC_0000, including address zero, gives hit=0, err=1 and word_addr=0 on the next cycle.
- R7: A cycle with req_valid=0 gives hit=0, err=0, word_addr=0 and bank_sel=0 on the next cycle, so err lasts one cycle per missed request.
- R8: remap_req is sampled on each clock edge (1 = flat, 0 = split); a request sampled on the same edge as a change uses the old mapping and a request on the following edge uses the new one, in either direction.
- R9: bank_sel equals word_addr[15:14], the 64 KiB bank that holds the word.
- R10: address bits [1:0] do not change any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| remap_req | input | 1 | Mapping select, 1 = flat top window, 0 = split windows |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Byte address of the request |
| hit | output | 1 | Request landed in an active RAM window |
| err | output | 1 | Request missed every active window |
| word_addr | output | 16 | RAM word address of a hit |
| bank_sel | output | 2 | 64 KiB bank of a hit |

## Verification
The decode is driven with the exact edges of every window (first and last word of each, and the word just outside), with addresses scattered over the whole 32-bit space, and with all four byte-lane offsets. Edge addresses separate an off-by-one window limit from a correct one, scattered addresses expose a miss region that wrongly hits, and byte offsets show whether bits [1:0] leak into the word. The remap input is toggled on the same edge as a request and again one edge before one, in both directions, which tells a correctly sampled mode from one that acts too early or too late.

// File: rtl/ocm_remap_pkg.sv
package ocm_remap_pkg;

    localparam int BUS_W = 32;

    typedef enum logic {
        MAP_SPLIT = 1'b0,
        MAP_FLAT  = 1'b1
    } map_mode_e;

    typedef struct packed {
        logic [BUS_W-1:0] base;
        logic [BUS_W-1:0] last;
        logic [BUS_W-1:0] ram_off;
        map_mode_e        mode;
    } win_desc_t;

    localparam int NUM_WIN = 3;

    function automatic logic [BUS_W-1:0] top_base(input int unsigned nbytes);
        return ~BUS_W'(nbytes) + BUS_W'(1);
    endfunction

    // window 0: low split part, 1: high split part, 2: flat window
    function automatic win_desc_t win_table(input int idx,
                                            input int unsigned ram_bytes,
                                            input int unsigned low_bytes);
        win_desc_t w;
        w.last = '1;
        case (idx)
            0: begin
                w.base    = '0;
                w.last    = BUS_W'(low_bytes) - BUS_W'(1);
                w.ram_off = '0;
                w.mode    = MAP_SPLIT;
            end
            1: begin
                w.base    = top_base(ram_bytes - low_bytes);
                w.ram_off = BUS_W'(low_bytes);
                w.mode    = MAP_SPLIT;
            end
            default: begin
                w.base    = top_base(ram_bytes);
                w.ram_off = '0;
                w.mode    = MAP_FLAT;
            end
        endcase
        return w;
    endfunction

endpackage

// File: rtl/ocm_mode_ctl.sv
module ocm_mode_ctl
    import ocm_remap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      remap_req,
    output map_mode_e mode_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MAP_SPLIT;
        end else begin
            mode_q <= remap_req ? MAP_FLAT : MAP_SPLIT;
        end
    end

endmodule

// File: rtl/ocm_win_match.sv
module ocm_win_match
    import ocm_remap_pkg::*;
#(
    parameter win_desc_t WIN = '0,
    parameter int        BW  = 18
) (
    input  logic [BUS_W-1:0] addr,
    input  map_mode_e        mode,
    output logic             match,
    output logic [BW-3:0]    word_off
);

    logic [BUS_W-1:0] rel;
    logic             unused_rel;

    assign rel        = addr - WIN.base;
    assign match      = (mode == WIN.mode) && (addr >= WIN.base) && (addr <= WIN.last);
    assign word_off   = rel[BW-1:2] + WIN.ram_off[BW-1:2];
    assign unused_rel = ^{rel[BUS_W-1:BW], rel[1:0]};

endmodule

// File: rtl/ocm_dec_out.sv
module ocm_dec_out #(
    parameter int WA     = 16,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic              hit_c,
    input  logic [WA-1:0]     word_c,
    output logic              hit,
    output logic              err,
    output logic [WA-1:0]     word_addr,
    output logic [BANK_W-1:0] bank_sel
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hit       <= 1'b0;
            err       <= 1'b0;
            word_addr <= '0;
            bank_sel  <= '0;
        end else begin
            hit       <= valid & hit_c;
            err       <= valid & ~hit_c;
            word_addr <= (valid & hit_c) ? word_c : '0;
            bank_sel  <= (valid & hit_c) ? word_c[WA-1 -: BANK_W] : '0;
        end
    end

endmodule

// File: rtl/ocm_addr_remap.sv
module ocm_addr_remap
    import ocm_remap_pkg::*;
#(
    parameter int RAM_KIB  = 256,
    parameter int LOW_KIB  = 192,
    parameter int BANK_KIB = 64,
    localparam int RAM_BYTES = RAM_KIB * 1024,
    localparam int BW        = $clog2(RAM_BYTES),
    localparam int WA        = BW - 2,
    localparam int BANK_W    = $clog2(RAM_KIB / BANK_KIB)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              remap_req,
    input  logic              req_valid,
    input  logic [31:0]       req_addr,
    output logic              hit,
    output logic              err,
    output logic [WA-1:0]     word_addr,
    output logic [BANK_W-1:0] bank_sel
);

    localparam int LOW_BYTES = LOW_KIB * 1024;

    map_mode_e     map_mode;
    logic          map_flat;
    logic [NUM_WIN-1:0] win_hit;
    logic [WA-1:0] win_word [NUM_WIN];
    logic          hit_c;
    logic [WA-1:0] word_c;

    ocm_mode_ctl u_mode (
        .clk       (clk),
        .rst       (rst),
        .remap_req (remap_req),
        .mode_q    (map_mode)
    );

    assign map_flat = (map_mode == MAP_FLAT);

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        localparam win_desc_t WD = win_table(g, RAM_BYTES, LOW_BYTES);
        ocm_win_match #(
            .WIN (WD),
            .BW  (BW)
        ) u_win (
            .addr     (req_addr),
            .mode     (map_mode),
            .match    (win_hit[g]),
            .word_off (win_word[g])
        );
    end

    always_comb begin
        word_c = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (win_hit[i]) begin
                word_c = word_c | win_word[i];
            end
        end
    end

    assign hit_c = |win_hit;

    ocm_dec_out #(
        .WA     (WA),
        .BANK_W (BANK_W)
    ) u_out (
        .clk       (clk),
        .rst       (rst),
        .valid     (req_valid),
        .hit_c     (hit_c),
        .word_c    (word_c),
        .hit       (hit),
        .err       (err),
        .word_addr (word_addr),
        .bank_sel  (bank_sel)
    );

endmodule

// File: rtl/ocm_addr_remap_chk.sv
module ocm_addr_remap_chk #(
    parameter int RAM_BYTES = 262144,
    parameter int LOW_BYTES = 196608,
    parameter int WA        = 16,
    parameter int BANK_W    = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              remap_req,
    input logic              map_flat,
    input logic              req_valid,
    input logic [31:0]       req_addr,
    input logic              hit,
    input logic              err,
    input logic [WA-1:0]     word_addr,
    input logic [BANK_W-1:0] bank_sel
);

    localparam logic [31:0] FLAT_BASE = ~32'(RAM_BYTES) + 32'd1;
    localparam logic [31:0] LOW_END   = 32'(LOW_BYTES);

    // R4
    hit_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(hit && err));

    // R4
    miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> (word_addr == '0 && bank_sel == '0));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(req_valid) |-> (!hit && !err));

    // R8
    mode_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (map_flat == $past(remap_req)));

    // R6
    flat_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(req_valid) && $past(map_flat) && $past(req_addr) < FLAT_BASE) |-> err);

    // R5
    flat_word_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(map_flat) && hit) |-> (word_addr == $past(req_addr[WA+1:2])));

    // R2
    split_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(req_valid) && !$past(map_flat) && $past(req_addr) < LOW_END)
            |-> (hit && word_addr == $past(req_addr[WA+1:2])));

endmodule

bind ocm_addr_remap ocm_addr_remap_chk #(
    .RAM_BYTES (RAM_BYTES),
    .LOW_BYTES (LOW_BYTES),
    .WA        (WA),
    .BANK_W    (BANK_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .remap_req (remap_req),
    .map_flat  (map_flat),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .hit       (hit),
    .err       (err),
    .word_addr (word_addr),
    .bank_sel  (bank_sel)
);

// File: tb/test_ocm_addr_remap.sv
module test_ocm_addr_remap;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        remap_req = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        hit, err;
    logic [15:0] word_addr;
    logic [1:0]  bank_sel;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    // reference state
    bit          m_flat = 0;
    bit          e_hit, e_err, e_ok = 0;
    int unsigned e_word;
    string       e_tag = "R1";
    string       phase = "";

    always #5 clk = ~clk;

    ocm_addr_remap i_ocm_addr_remap (
        .clk       (clk),
        .rst       (rst),
        .remap_req (remap_req),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .hit       (hit),
        .err       (err),
        .word_addr (word_addr),
        .bank_sel  (bank_sel)
    );

    function automatic void ref_decode(input logic [31:0] a, input bit flat,
                                       output bit h, output int unsigned w,
                                       output string tag);
        h = 0; w = 0;
        if (!flat) begin
            if (a < 32'h0003_0000) begin
                h = 1; w = a / 4; tag = "R2";
            end else if (a >= 32'hFFFF_0000) begin
                h = 1; w = 49152 + (a - 32'hFFFF_0000) / 4; tag = "R3";
            end else begin
                tag = "R4";
            end
        end else begin
            if (a >= 32'hFFFC_0000) begin
                h = 1; w = (a - 32'hFFFC_0000) / 4; tag = "R5";
            end else begin
                tag = "R6";
            end
        end
        if (a[1:0] != 2'b00) tag = {tag, "+R10"};
    endfunction

    always @(posedge clk) begin
        bit          h;
        int unsigned w;
        string       t;
        if (rst) begin
            e_hit = 0; e_err = 0; e_word = 0; e_tag = "R1";
            m_flat = 0;
        end else begin
            if (req_valid) begin
                ref_decode(req_addr, m_flat, h, w, t);
                e_hit = h; e_err = !h; e_word = w; e_tag = t;
            end else begin
                e_hit = 0; e_err = 0; e_word = 0; e_tag = "R7";
            end
            m_flat = remap_req;
        end
        e_tag = {e_tag, phase};
        e_ok = 1;
    end

    task automatic check(input string tag, input int unsigned act, input int unsigned exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (e_ok && !done) begin
            check({e_tag, " hit"}, hit, e_hit);
            check({e_tag, " err"}, err, e_err);
            check({e_tag, " word"}, word_addr, e_word);
            check({e_tag, "+R9 bank"}, bank_sel, e_word / 16384);
        end
    end

    task automatic issue(input logic [31:0] a, input bit v, input bit r);
        @(negedge clk);
        req_addr  = a;
        req_valid = v;
        remap_req = r;
    endtask

    logic [31:0] edges [14] = '{
        32'h0000_0000, 32'h0000_0004, 32'h0002_FFFC, 32'h0003_0000,
        32'h0003_FFFC, 32'h8000_0000, 32'hFFFB_FFFC, 32'hFFFC_0000,
        32'hFFFE_FFFC, 32'hFFFF_0000, 32'hFFFF_8000, 32'hFFFF_FFFC,
        32'h0001_2344, 32'hFFFD_0010
    };

    task automatic sweep(input bit r);
        logic [31:0] lcg = 32'h1234_5678;
        foreach (edges[i]) issue(edges[i], 1, r);
        for (int i = 0; i < 40; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            issue(lcg, 1, r);
            issue({14'h3FFF, lcg[17:0]}, 1, r);
            issue({14'h0, lcg[17:0]}, 1, r);
            if (i % 5 == 0) issue(lcg, 0, r);
        end
        for (int b = 0; b < 4; b++) begin
            issue(32'h0000_0100 + 32'(b), 1, r);
            issue(32'hFFFF_0100 + 32'(b), 1, r);
            issue(32'hFFFC_0100 + 32'(b), 1, r);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs held clear through reset (checked by the clock compare)
        issue(32'h0000_0000, 1, 1);
        rst = 0;
        issue(32'h0000_0000, 0, 0);
        issue(32'h0000_0000, 0, 0);
        phase = " R7";
        issue(32'h0000_0010, 0, 0);
        phase = "";
        sweep(0);
        phase = " R8";
        issue(32'hFFFC_0000, 1, 1);   // same edge as change: split rule
        issue(32'hFFFC_0000, 1, 1);   // next edge: flat rule
        issue(32'h0000_0000, 1, 0);   // same edge as change back: flat rule
        issue(32'h0000_0000, 1, 0);   // split rule again
        issue(32'hFFFC_0004, 1, 1);
        phase = "";
        sweep(1);
        phase = " R8";
        issue(32'h0000_0008, 1, 0);
        issue(32'h0000_0008, 1, 0);
        phase = "";
        sweep(0);
        phase = " R1";
        issue(32'hFFFF_0000, 1, 1);
        issue(32'hFFFF_0000, 1, 1);
        rst = 1;
        issue(32'hFFFF_0000, 1, 1);
        issue(32'hFFFF_0000, 1, 0);
        rst = 0;
        issue(32'hFFFC_0000, 1, 0);   // must still be split after reset
        issue(32'h0000_0000, 0, 0);
        issue(32'h0000_0000, 0, 0);
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=<20000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule